// File: doc/BRIEF.md
# Legacy INTx Gating State Machine

This block sits between one PCI function's internal interrupt source and its legacy INTx wires. The device logic sends single-cycle request and release events. The block combines them with a permission condition and decides whether the line is raised. Permission comes from the command register's interrupt-disable bit and from the two message-signalled interrupt enables.

A request that arrives while interrupts are not allowed is remembered, not dropped. It is raised once permission returns. If permission is removed while the line is up, the line is withdrawn and the request is held until permission returns. The line is driven out twice, on the same cycle and from the same request: once toward an I/O APIC input and once toward an interrupt-router link input. A function whose interrupt-pin field is zero has no line and never drives either output.

Top module: `intx_gate`

## Requirements
- R1: After reset both outputs are low and the block holds no request.
- R2: A request event with no request held and permission present raises both outputs on the next clock edge.
- R3: A request event without permission keeps the outputs low but is held. The outputs rise on the edge after the cycle in which permission is present again.
- R4: Permission is present only when `cmd_intx_off` is 0, `msi_en` is 0 and `msix_en` is 0. Any one of them at 1 removes it.
- R5: A request event while a request is already raised or held changes nothing. A single release event still clears it.
- R6: A release event while the line is raised drops both outputs on the next edge. A release event with nothing held has no effect.
- R7: A release event while a request is held without permission discards it. The outputs stay low when permission returns.
- R8: Removing permission while the line is raised drops both outputs on the next edge. The request stays held and rises again when permission returns.
- R9: `apic_req` and `link_req` are equal in every cycle.
- R10: While `int_pin` is 0, both outputs are low and events are ignored. A held or raised request is discarded.
- R11: An event is judged against the permission inputs present in the same cycle, even if they changed in that cycle.
- R12: A request and a release event in the same cycle act as a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq_set | input | 1 | Single-cycle request event from the device |
| dev_irq_clr | input | 1 | Single-cycle release event from the device |
| cmd_intx_off | input | 1 | Command-register interrupt-disable bit |
| msi_en | input | 1 | MSI enable flag |
| msix_en | input | 1 | MSI-X enable flag |
| int_pin | input | PIN_W | Interrupt-pin field; 0 means no pin |
| apic_req | output | 1 | Line request toward the I/O APIC input |
| link_req | output | 1 | Line request toward the router link input |

## Verification
The properties assume that the events are plain single-cycle levels sampled at the clock. They also assume that `int_pin` and the permission bits may change in any cycle, including the cycle of an event. The properties place no limit on how often events arrive, so they also hold if events are stretched or repeated. The stimulus changes every input only at the falling edge. It deliberately lines up events with permission changes and with each other, which covers the same-cycle cases in R11 and R12.

// File: rtl/intx_pkg.sv
package intx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ASSERTED = 2'd1,
    ST_PENDING  = 2'd2
  } intx_st_e;

  // Line may be raised only with legacy interrupts enabled and no message mode on.
  function automatic logic permit_f(input logic intx_off, input logic msi, input logic msix);
    return !intx_off && !msi && !msix;
  endfunction

  // Next state; a release event outranks a request event.
  function automatic intx_st_e next_f(input intx_st_e cur, input logic set_ev,
                                      input logic clr_ev, input logic ok);
    intx_st_e nx;
    if (clr_ev) begin
      nx = ST_IDLE;
    end else begin
      unique case (cur)
        ST_IDLE:     nx = set_ev ? (ok ? ST_ASSERTED : ST_PENDING) : ST_IDLE;
        ST_ASSERTED: nx = ok ? ST_ASSERTED : ST_PENDING;
        ST_PENDING:  nx = ok ? ST_ASSERTED : ST_PENDING;
        default:     nx = ST_IDLE;
      endcase
    end
    return nx;
  endfunction

endpackage

// File: rtl/intx_permit.sv
module intx_permit #(
  parameter int PIN_W = 8
) (
  input  logic             cmd_intx_off,
  input  logic             msi_en,
  input  logic             msix_en,
  input  logic [PIN_W-1:0] int_pin,
  output logic             permit,
  output logic             pin_ok
);
  import intx_pkg::*;

  always_comb begin
    permit = permit_f(cmd_intx_off, msi_en, msix_en);
    pin_ok = |int_pin;
  end
endmodule

// File: rtl/intx_fsm.sv
module intx_fsm (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_ev,
  input  logic               clr_ev,
  input  logic               permit,
  input  logic               pin_ok,
  output intx_pkg::intx_st_e st,
  output logic               req_next
);
  import intx_pkg::*;

  intx_st_e st_nx;

  always_comb begin
    if (!pin_ok) st_nx = ST_IDLE;
    else         st_nx = next_f(st, set_ev, clr_ev, permit);
    req_next = (st_nx == ST_ASSERTED);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end
endmodule

// File: rtl/intx_drive.sv
module intx_drive #(
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_next,
  output logic [NUM_OUT-1:0] line_q
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n) line_q[i] <= 1'b0;
      else        line_q[i] <= req_next;
    end
  end
endmodule

// File: rtl/intx_gate.sv
module intx_gate #(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_irq_set,
  input  logic             dev_irq_clr,
  input  logic             cmd_intx_off,
  input  logic             msi_en,
  input  logic             msix_en,
  input  logic [PIN_W-1:0] int_pin,
  output logic             apic_req,
  output logic             link_req
);
  import intx_pkg::*;

  localparam int NUM_OUT = 2;
  localparam int OUT_APIC = 0;
  localparam int OUT_LINK = 1;

  logic               permit_w;
  logic               pin_ok_w;
  logic               req_next_w;
  intx_st_e           fsm_st;
  logic [NUM_OUT-1:0] lines;

  intx_permit #(.PIN_W(PIN_W)) u_permit (
    .cmd_intx_off(cmd_intx_off),
    .msi_en      (msi_en),
    .msix_en     (msix_en),
    .int_pin     (int_pin),
    .permit      (permit_w),
    .pin_ok      (pin_ok_w)
  );

  intx_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (dev_irq_set),
    .clr_ev  (dev_irq_clr),
    .permit  (permit_w),
    .pin_ok  (pin_ok_w),
    .st      (fsm_st),
    .req_next(req_next_w)
  );

  intx_drive #(.NUM_OUT(NUM_OUT)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_next(req_next_w),
    .line_q  (lines)
  );

  assign apic_req = lines[OUT_APIC];
  assign link_req = lines[OUT_LINK];
endmodule

// File: rtl/intx_gate_chk.sv
module intx_gate_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               dev_irq_set,
  input logic               dev_irq_clr,
  input logic               permit_w,
  input logic               pin_ok_w,
  input intx_pkg::intx_st_e fsm_st,
  input logic               apic_req,
  input logic               link_req
);
  import intx_pkg::*;

  // R9
  out_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apic_req == link_req);

  // R2
  raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq_set && !dev_irq_clr && permit_w && pin_ok_w && fsm_st == ST_IDLE) |=> apic_req);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq_clr |=> !apic_req);

  // R8
  no_permit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !permit_w |=> !apic_req);

  // R3
  replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_st == ST_PENDING && permit_w && pin_ok_w && !dev_irq_clr) |=> apic_req);

  // R10
  no_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_ok_w |=> (!apic_req && fsm_st == ST_IDLE));
endmodule

bind intx_gate intx_gate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dev_irq_set(dev_irq_set),
  .dev_irq_clr(dev_irq_clr),
  .permit_w   (permit_w),
  .pin_ok_w   (pin_ok_w),
  .fsm_st     (fsm_st),
  .apic_req   (apic_req),
  .link_req   (link_req)
);

// File: tb/intx_gate_test.sv
module intx_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dev_irq_set = 1'b0;
  logic       dev_irq_clr = 1'b0;
  logic       cmd_intx_off = 1'b0;
  logic       msi_en = 1'b0;
  logic       msix_en = 1'b0;
  logic [7:0] int_pin = 8'd1;
  logic       apic_req;
  logic       link_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intx_gate uut (
    .clk(clk), .rst_n(rst_n), .dev_irq_set(dev_irq_set), .dev_irq_clr(dev_irq_clr),
    .cmd_intx_off(cmd_intx_off), .msi_en(msi_en), .msix_en(msix_en),
    .int_pin(int_pin), .apic_req(apic_req), .link_req(link_req)
  );

  // {set, clr, intx_off, msi, msix, expected line, requirement number}
  typedef struct packed {
    logic       s;
    logic       c;
    logic       off;
    logic       msi;
    logic       msix;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{0,0,0,0,0,0,4'd6},   // R6 idle, nothing
    '{1,0,0,0,0,1,4'd2},   // R2 raise
    '{1,0,0,0,0,1,4'd5},   // R5 repeat request ignored
    '{0,1,0,0,0,0,4'd6},   // R6 single release drops
    '{0,1,0,0,0,0,4'd6},   // R6 release in idle: no effect
    '{1,0,1,0,0,0,4'd3},   // R3 masked request held
    '{1,0,1,0,0,0,4'd5},   // R5 repeat while held
    '{0,0,0,0,0,1,4'd3},   // R3 replay on permission
    '{0,0,0,1,0,0,4'd4},   // R4 msi removes permission
    '{0,0,0,0,1,0,4'd4},   // R4 msix removes permission
    '{0,0,0,0,0,1,4'd8},   // R8 regrant raises again
    '{0,1,0,0,0,0,4'd6},   // R6
    '{1,0,1,0,0,0,4'd3},   // R3 held
    '{0,1,1,0,0,0,4'd7},   // R7 release discards held
    '{0,0,0,0,0,0,4'd7},   // R7 nothing replayed
    '{0,0,1,0,0,0,4'd11},  // R11 masked, idle
    '{1,0,0,0,0,1,4'd11},  // R11 unmask in event cycle
    '{0,1,0,0,0,0,4'd6},   // R6
    '{1,0,0,1,0,0,4'd11},  // R11 msi set in event cycle
    '{0,1,0,0,0,0,4'd7},   // R7
    '{1,1,0,0,0,0,4'd12},  // R12 both events from idle
    '{0,0,0,0,0,0,4'd12},  // R12 stays idle
    '{1,0,0,0,0,1,4'd2},   // R2
    '{1,1,0,0,0,0,4'd12}   // R12 both events while raised
  };

  task automatic check(input logic exp, input string tag);
    checks++;
    if (apic_req !== exp || link_req !== exp) begin
      errors++;
      $display("FAIL %s apic=%b link=%b expected=%b", tag, apic_req, link_req, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample 5 ns later.
  task automatic step(input logic s, input logic c, input logic off,
                      input logic m, input logic mx, input logic [7:0] pin);
    dev_irq_set = s; dev_irq_clr = c; cmd_intx_off = off;
    msi_en = m; msix_en = mx; int_pin = pin;
    @(posedge clk);
    #5;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired apic=%b link=%b expected=done", apic_req, link_req);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(1'b0, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].s, VECS[i].c, VECS[i].off, VECS[i].msi, VECS[i].msix, 8'd1);
      check(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
      @(negedge clk);
    end

    // R10: no pin, request ignored
    step(0, 1, 0, 0, 0, 8'd1); @(negedge clk);
    step(1, 0, 0, 0, 0, 8'd0);
    check(1'b0, "R10 request with pin zero");
    @(negedge clk);
    step(0, 0, 0, 0, 0, 8'd1);
    check(1'b0, "R10 ignored request not kept");
    @(negedge clk);
    // R10: raised line dropped when pin goes to zero, and not restored
    step(1, 0, 0, 0, 0, 8'd4);
    check(1'b1, "R2 raise with pin 4");
    @(negedge clk);
    step(0, 0, 0, 0, 0, 8'd0);
    check(1'b0, "R10 pin cleared while raised");
    @(negedge clk);
    step(0, 0, 0, 0, 0, 8'd4);
    check(1'b0, "R10 raised request discarded");
    @(negedge clk);
    // R10: held request discarded too
    step(1, 0, 1, 0, 0, 8'd4); @(negedge clk);
    step(0, 0, 1, 0, 0, 8'd0); @(negedge clk);
    step(0, 0, 0, 0, 0, 8'd4);
    check(1'b0, "R10 held request discarded");
    @(negedge clk);

    // R1: reset while raised
    step(1, 0, 0, 0, 0, 8'd1);
    check(1'b1, "R2 raise before reset");
    @(negedge clk);
    rst_n = 1'b0;
    step(0, 0, 0, 0, 0, 8'd1);
    check(1'b0, "R1 reset clears raised line");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 8'd1);
    check(1'b0, "R1 nothing held after reset");
    @(negedge clk);

    finish_run();
  end
endmodule